// File: doc/BRIEF.md
# Machine-Mode Trap and Return Controller

This block keeps the privileged state of a 64-bit core that runs in only two privilege levels, user and machine. It holds the current level, the interrupt-enable, previous-enable and previous-level fields of the machine status word, and four machine registers: the exception PC, the cause, the trap value and the trap vector. The pipeline sends a one-cycle trap request with a 4-bit cause, the PC of the faulting instruction and an optional faulting value. The block then saves that context, enters machine mode and returns the vector as the next PC.

A one-cycle return request undoes the entry. It restores the enable bit and the privilege level, and it returns the saved exception PC. Two simple write ports let software-visible logic load the vector and the exception PC. Every update appears on the clock edge that samples the request. For one cycle after that edge, `next_pc_valid` marks `next_pc` as meaningful.

Top module: `mtrap_ctrl`

## Requirements
- R1: After a synchronous active-low reset the level is machine (2'b11), the status word reads zero, the trap vector holds `RESET_VEC`, and `next_pc_valid` and `addr_missing_err` are 0.
- R2: On a trap, the exception PC takes `trap_pc` and the cause register takes the 4-bit `trap_cause` zero-extended to 64 bits. The codes are: misaligned fetch 0, fetch access 1, illegal instruction 2, breakpoint 3, misaligned load 4, load access 5, misaligned store 6, store access 7, ecall from user 8, supervisor 9 and machine 11, page faults on fetch 12, load 13 and store 15, with 10 and 14 reserved.
- R3: On a trap, previous-enable (status bit 7) takes the old enable (bit 3) and the enable is cleared. Previous-level (bits 12:11) records the level before the trap, and the level becomes machine. Levels are encoded as user 2'b00 and machine 2'b11.
- R4: One cycle after a trap or a return request, `next_pc_valid` is 1 for exactly one cycle. After a trap, `next_pc` equals the vector value that was held before that edge.
- R5: For causes 8, 9 and 11 and for the reserved codes 10 and 14, the trap value is written with zero. For cause 3 it is written with `trap_pc`.
- R6: For causes 0, 1, 2, 4, 5, 6, 7, 12, 13 and 15 with `trap_fault_valid` high, the trap value takes `trap_fault_val` and `addr_missing_err` stays 0.
- R7: For one of the causes in R6 with `trap_fault_valid` low, `addr_missing_err` pulses for one cycle. The trap still completes, with the trap value set to zero.
- R8: On a return, the enable takes previous-enable and previous-enable becomes 1. The level takes previous-level, previous-level becomes user, and `next_pc` equals the exception PC.
- R9: When a trap and a return are requested in the same cycle, only the trap takes effect.
- R10: `tvec_wr_en` loads the vector and `epc_wr_en` loads the exception PC. A trap in the same cycle overrides the exception PC write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | One-cycle synchronous exception request |
| trap_cause | input | 4 | Exception cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_fault_val | input | XLEN | Faulting address or instruction value |
| trap_fault_valid | input | 1 | `trap_fault_val` is present |
| mret_req | input | 1 | One-cycle return request |
| tvec_wr_en | input | 1 | Load the trap vector |
| tvec_wr_data | input | XLEN | New trap vector |
| epc_wr_en | input | 1 | Load the exception PC |
| epc_wr_data | input | XLEN | New exception PC |
| next_pc_valid | output | 1 | `next_pc` is meaningful this cycle |
| next_pc | output | XLEN | Redirect target |
| priv_lvl | output | 2 | Current privilege level |
| mstatus_o | output | XLEN | Status word (bits 3, 7, 12:11 populated) |
| epc_o | output | XLEN | Exception PC register |
| cause_o | output | XLEN | Cause register |
| tval_o | output | XLEN | Trap value register |
| tvec_o | output | XLEN | Trap vector register |
| addr_missing_err | output | 1 | Address-carrying cause arrived without a value |

## Verification
The assertions assume three things about the inputs: requests are single-cycle pulses, nothing is requested while reset is held, and the privilege level only ever takes the two legal encodings. The last holds because both trap entry and reset write only legal values. The bench therefore raises each request for exactly one cycle and keeps all requests low during reset. It exercises the trap-plus-return collision and the write-port-plus-trap collisions as deliberate single-cycle overlaps, not as sustained levels.

// File: rtl/mtrap_pkg.sv
// Package: shared encodings for the machine-mode trap controller.
// Assumes a two-level privilege model (user and machine only).
package mtrap_pkg;

    localparam logic [1:0] PRIV_USER    = 2'b00;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    // Status word bit positions consumed by software.
    localparam int ST_MIE_BIT    = 3;
    localparam int ST_MPIE_BIT   = 7;
    localparam int ST_MPP_LO_BIT = 11;
    localparam int ST_MPP_HI_BIT = 12;

    typedef enum logic [3:0] {
        CAUSE_FETCH_MISALIGN = 4'd0,
        CAUSE_FETCH_ACCESS   = 4'd1,
        CAUSE_ILLEGAL        = 4'd2,
        CAUSE_BREAK          = 4'd3,
        CAUSE_LOAD_MISALIGN  = 4'd4,
        CAUSE_LOAD_ACCESS    = 4'd5,
        CAUSE_STORE_MISALIGN = 4'd6,
        CAUSE_STORE_ACCESS   = 4'd7,
        CAUSE_CALL_U         = 4'd8,
        CAUSE_CALL_S         = 4'd9,
        CAUSE_RSVD_A         = 4'd10,
        CAUSE_CALL_M         = 4'd11,
        CAUSE_FETCH_PAGE     = 4'd12,
        CAUSE_LOAD_PAGE      = 4'd13,
        CAUSE_RSVD_E         = 4'd14,
        CAUSE_STORE_PAGE     = 4'd15
    } cause_e;

    // How the trap value register is filled for a given cause.
    typedef enum logic [1:0] {
        TVAL_ZERO  = 2'd0,
        TVAL_FAULT = 2'd1,
        TVAL_PC    = 2'd2
    } tval_src_e;

    // Map a cause code to its trap value source.
    function automatic tval_src_e cause_tval_src(input logic [3:0] code);
        tval_src_e src;
        case (cause_e'(code))
            CAUSE_BREAK:  src = TVAL_PC;
            CAUSE_CALL_U,
            CAUSE_CALL_S,
            CAUSE_CALL_M,
            CAUSE_RSVD_A,
            CAUSE_RSVD_E: src = TVAL_ZERO;
            default:      src = TVAL_FAULT;
        endcase
        return src;
    endfunction

endpackage

// File: rtl/mtrap_tval_sel.sv
// Module: mtrap_tval_sel
// Combinational selection of the trap value written on trap entry, plus
// detection of an address-carrying cause raised without a value.
// Assumes the inputs are only meaningful while a trap is being requested.
module mtrap_tval_sel
    import mtrap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      cause,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] fault_val,
    input  logic            fault_valid,
    output logic [XLEN-1:0] tval_next,
    output logic            missing
);

    tval_src_e src;

    // Classify the cause.
    always_comb src = cause_tval_src(cause);

    // Pick the value and flag a missing faulting value.
    always_comb begin
        tval_next = '0;
        missing   = 1'b0;
        case (src)
            TVAL_PC:    tval_next = pc;
            TVAL_FAULT: begin
                if (fault_valid) tval_next = fault_val;
                else             missing   = 1'b1;
            end
            default:    tval_next = '0;
        endcase
    end

endmodule

// File: rtl/mtrap_status.sv
// Module: mtrap_status
// Holds the privilege level and the enable / previous-enable /
// previous-level status fields; applies trap entry and return.
// Assumes do_trap already has priority over do_ret resolved upstream.
module mtrap_status
    import mtrap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       do_trap,
    input  logic       do_ret,
    output logic [1:0] priv,
    output logic       st_mie,
    output logic       st_mpie,
    output logic [1:0] st_mpp
);

    // Update privilege and status fields on trap entry or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv    <= PRIV_MACHINE;
            st_mie  <= 1'b0;
            st_mpie <= 1'b0;
            st_mpp  <= PRIV_USER;
        end else if (do_trap) begin
            st_mpie <= st_mie;
            st_mie  <= 1'b0;
            st_mpp  <= priv;
            priv    <= PRIV_MACHINE;
        end else if (do_ret) begin
            st_mie  <= st_mpie;
            st_mpie <= 1'b1;
            priv    <= st_mpp;
            st_mpp  <= PRIV_USER;
        end
    end

endmodule

// File: rtl/mtrap_regs.sv
// Module: mtrap_regs
// Exception PC, cause, trap value and vector registers, and the registered
// redirect output. Assumes do_trap/do_ret are mutually exclusive.
module mtrap_regs #(
    parameter int              XLEN      = 64,
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_trap,
    input  logic            do_ret,
    input  logic [3:0]      cause,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] tval_next,
    input  logic            missing,
    input  logic            tvec_we,
    input  logic [XLEN-1:0] tvec_wd,
    input  logic            epc_we,
    input  logic [XLEN-1:0] epc_wd,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] mcause,
    output logic [XLEN-1:0] tval,
    output logic [XLEN-1:0] tvec,
    output logic [XLEN-1:0] redir_pc,
    output logic            redir_vld,
    output logic            err
);

    localparam int CAUSE_PAD = XLEN - 4;

    // Exception PC: trap capture beats the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)       epc <= '0;
        else if (do_trap) epc <= pc;
        else if (epc_we)  epc <= epc_wd;
    end

    // Cause and trap value captured on trap entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcause <= '0;
            tval   <= '0;
        end else if (do_trap) begin
            mcause <= {{CAUSE_PAD{1'b0}}, cause};
            tval   <= tval_next;
        end
    end

    // Trap vector, loaded only through its write port.
    always_ff @(posedge clk) begin
        if (!rst_n)       tvec <= RESET_VEC;
        else if (tvec_we) tvec <= tvec_wd;
    end

    // Redirect target, its valid pulse and the missing-value pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_pc  <= '0;
            redir_vld <= 1'b0;
            err       <= 1'b0;
        end else begin
            redir_vld <= do_trap | do_ret;
            err       <= do_trap & missing;
            if (do_trap)     redir_pc <= tvec;
            else if (do_ret) redir_pc <= epc;
        end
    end

endmodule

// File: rtl/mtrap_ctrl.sv
// Module: mtrap_ctrl (top)
// Machine-mode trap entry and return controller for a two-level core.
// Assumes trap_req and mret_req are single-cycle pulses; a trap wins
// over a simultaneous return.
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter logic [XLEN-1:0] RESET_VEC = {{(XLEN-32){1'b0}}, 32'h8000_0000}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [3:0]      trap_cause,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] trap_fault_val,
    input  logic            trap_fault_valid,
    input  logic            mret_req,
    input  logic            tvec_wr_en,
    input  logic [XLEN-1:0] tvec_wr_data,
    input  logic            epc_wr_en,
    input  logic [XLEN-1:0] epc_wr_data,
    output logic            next_pc_valid,
    output logic [XLEN-1:0] next_pc,
    output logic [1:0]      priv_lvl,
    output logic [XLEN-1:0] mstatus_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] cause_o,
    output logic [XLEN-1:0] tval_o,
    output logic [XLEN-1:0] tvec_o,
    output logic            addr_missing_err
);

    logic            do_trap;
    logic            do_ret;
    logic [XLEN-1:0] tval_next;
    logic            missing;
    logic            st_mie;
    logic            st_mpie;
    logic [1:0]      st_mpp;

    // Resolve request priority: trap first.
    always_comb begin
        do_trap = trap_req;
        do_ret  = mret_req & ~trap_req;
    end

    mtrap_tval_sel #(.XLEN(XLEN)) tval_sel_i (
        .cause       (trap_cause),
        .pc          (trap_pc),
        .fault_val   (trap_fault_val),
        .fault_valid (trap_fault_valid),
        .tval_next   (tval_next),
        .missing     (missing)
    );

    mtrap_status status_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_trap (do_trap),
        .do_ret  (do_ret),
        .priv    (priv_lvl),
        .st_mie  (st_mie),
        .st_mpie (st_mpie),
        .st_mpp  (st_mpp)
    );

    mtrap_regs #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_trap   (do_trap),
        .do_ret    (do_ret),
        .cause     (trap_cause),
        .pc        (trap_pc),
        .tval_next (tval_next),
        .missing   (missing),
        .tvec_we   (tvec_wr_en),
        .tvec_wd   (tvec_wr_data),
        .epc_we    (epc_wr_en),
        .epc_wd    (epc_wr_data),
        .epc       (epc_o),
        .mcause    (cause_o),
        .tval      (tval_o),
        .tvec      (tvec_o),
        .redir_pc  (next_pc),
        .redir_vld (next_pc_valid),
        .err       (addr_missing_err)
    );

    // Assemble the visible status word from its fields.
    always_comb begin
        mstatus_o = '0;
        mstatus_o[ST_MIE_BIT]                   = st_mie;
        mstatus_o[ST_MPIE_BIT]                  = st_mpie;
        mstatus_o[ST_MPP_HI_BIT:ST_MPP_LO_BIT]  = st_mpp;
    end

endmodule

// File: rtl/mtrap_ctrl_chk.sv
// Module: mtrap_ctrl_chk
// Port-level temporal checks for mtrap_ctrl, bound to every instance.
// Assumes requests are idle while reset is held.
module mtrap_ctrl_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_req,
    input logic [3:0]      trap_cause,
    input logic [XLEN-1:0] trap_pc,
    input logic            trap_fault_valid,
    input logic            mret_req,
    input logic            next_pc_valid,
    input logic [XLEN-1:0] next_pc,
    input logic [1:0]      priv_lvl,
    input logic [XLEN-1:0] mstatus_o,
    input logic [XLEN-1:0] epc_o,
    input logic [XLEN-1:0] cause_o,
    input logic [XLEN-1:0] tvec_o,
    input logic            addr_missing_err
);

    // R2: exception PC and cause captured on trap.
    assert_trap_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (epc_o == $past(trap_pc)) && (cause_o[3:0] == $past(trap_cause))
                     && (cause_o[XLEN-1:4] == '0));

    // R3: status fields and level on trap.
    assert_trap_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (priv_lvl == 2'b11) && !mstatus_o[3]
                     && (mstatus_o[7] == $past(mstatus_o[3]))
                     && (mstatus_o[12:11] == $past(priv_lvl)));

    // R3: level only takes legal encodings.
    assert_priv_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl == 2'b00) || (priv_lvl == 2'b11));

    // R4: redirect to old vector, one-cycle valid.
    assert_trap_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> next_pc_valid && (next_pc == $past(tvec_o)));

    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req && !mret_req |=> !next_pc_valid);

    // R7: missing-value error only after a trap without a value.
    assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_missing_err |-> $past(trap_req) && !$past(trap_fault_valid));

    // R8 and R9: return effects when no trap competes.
    assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mret_req && !trap_req |=> (mstatus_o[3] == $past(mstatus_o[7])) && mstatus_o[7]
                     && (priv_lvl == $past(mstatus_o[12:11]))
                     && (mstatus_o[12:11] == 2'b00) && (next_pc == $past(epc_o)));

    assert_trap_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req && mret_req |=> (priv_lvl == 2'b11) && (next_pc == $past(tvec_o)));

endmodule

bind mtrap_ctrl mtrap_ctrl_chk #(.XLEN(XLEN)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .trap_req         (trap_req),
    .trap_cause       (trap_cause),
    .trap_pc          (trap_pc),
    .trap_fault_valid (trap_fault_valid),
    .mret_req         (mret_req),
    .next_pc_valid    (next_pc_valid),
    .next_pc          (next_pc),
    .priv_lvl         (priv_lvl),
    .mstatus_o        (mstatus_o),
    .epc_o            (epc_o),
    .cause_o          (cause_o),
    .tvec_o           (tvec_o),
    .addr_missing_err (addr_missing_err)
);

// File: tb/mtrap_ctrl_tb_top.sv
// Directed bench for mtrap_ctrl: one task per scenario.
module mtrap_ctrl_tb_top;

    localparam int          XLEN = 64;
    localparam logic [63:0] RVEC = 64'h8000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            trap_req = 1'b0;
    logic [3:0]      trap_cause = '0;
    logic [XLEN-1:0] trap_pc = '0;
    logic [XLEN-1:0] trap_fault_val = '0;
    logic            trap_fault_valid = 1'b0;
    logic            mret_req = 1'b0;
    logic            tvec_wr_en = 1'b0;
    logic [XLEN-1:0] tvec_wr_data = '0;
    logic            epc_wr_en = 1'b0;
    logic [XLEN-1:0] epc_wr_data = '0;
    logic            next_pc_valid;
    logic [XLEN-1:0] next_pc;
    logic [1:0]      priv_lvl;
    logic [XLEN-1:0] mstatus_o, epc_o, cause_o, tval_o, tvec_o;
    logic            addr_missing_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mtrap_ctrl #(.XLEN(XLEN), .RESET_VEC(RVEC)) dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Raise requests for one cycle; return at the next falling edge.
    task automatic pulse(input logic t, input logic r, input logic [3:0] c,
                         input logic [63:0] pc, input logic [63:0] fv, input logic fvld);
        trap_req = t; mret_req = r; trap_cause = c;
        trap_pc = pc; trap_fault_val = fv; trap_fault_valid = fvld;
        @(negedge clk);
        trap_req = 1'b0; mret_req = 1'b0; trap_fault_valid = 1'b0;
        tvec_wr_en = 1'b0; epc_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 priv", 64'(priv_lvl), 64'h3);
        chk("R1 mstatus", mstatus_o, 64'h0);
        chk("R1 tvec", tvec_o, RVEC);
        chk("R1 valid", 64'(next_pc_valid), 64'h0);
        chk("R1 err", 64'(addr_missing_err), 64'h0);
    endtask

    task automatic t_write_ports();
        epc_wr_en = 1'b1; epc_wr_data = 64'h2000;
        tvec_wr_en = 1'b1; tvec_wr_data = 64'h4000;
        pulse(1'b0, 1'b0, 4'd0, 64'h0, 64'h0, 1'b0);
        chk("R10 epc write", epc_o, 64'h2000);
        chk("R10 tvec write", tvec_o, 64'h4000);
        // Trap together with both writes: epc write loses, vector read is old.
        epc_wr_en = 1'b1; epc_wr_data = 64'h9999;
        tvec_wr_en = 1'b1; tvec_wr_data = 64'h5000;
        pulse(1'b1, 1'b0, 4'd2, 64'h100, 64'hbad0, 1'b1);
        chk("R10 trap beats epc write", epc_o, 64'h100);
        chk("R4 old vector used", next_pc, 64'h4000);
        chk("R10 tvec updated", tvec_o, 64'h5000);
        chk("R3 mstatus from machine", mstatus_o, 64'h1800);
        chk("R6 illegal tval", tval_o, 64'hbad0);
    endtask

    task automatic t_return();
        pulse(1'b0, 1'b1, 4'd0, 64'h0, 64'h0, 1'b0);
        chk("R8 priv from MPP", 64'(priv_lvl), 64'h3);
        chk("R8 mstatus", mstatus_o, 64'h80);
        chk("R8 next pc", next_pc, 64'h100);
        chk("R4 valid", 64'(next_pc_valid), 64'h1);
        @(negedge clk);
        chk("R4 valid drops", 64'(next_pc_valid), 64'h0);
        pulse(1'b0, 1'b1, 4'd0, 64'h0, 64'h0, 1'b0);
        chk("R8 second return priv user", 64'(priv_lvl), 64'h0);
        chk("R8 second return mstatus", mstatus_o, 64'h88);
    endtask

    task automatic t_ecall();
        pulse(1'b1, 1'b0, 4'd8, 64'h300, 64'hdead, 1'b1);
        chk("R5 ecall tval zero", tval_o, 64'h0);
        chk("R2 cause", cause_o, 64'h8);
        chk("R2 epc", epc_o, 64'h300);
        chk("R3 mstatus from user", mstatus_o, 64'h80);
        chk("R3 priv machine", 64'(priv_lvl), 64'h3);
        chk("R4 vector", next_pc, 64'h5000);
        pulse(1'b1, 1'b0, 4'd9, 64'h304, 64'h1, 1'b1);
        chk("R5 cause 9 tval", tval_o, 64'h0);
        pulse(1'b1, 1'b0, 4'd11, 64'h308, 64'h1, 1'b1);
        chk("R5 cause 11 tval", tval_o, 64'h0);
        chk("R2 cause 11", cause_o, 64'hb);
    endtask

    task automatic t_addr_causes();
        logic [3:0] list [10] = '{4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd15};
        for (int i = 0; i < 10; i++) begin
            pulse(1'b1, 1'b0, list[i], 64'h1000 + 64'(i), 64'hf000_0000 + 64'(i * 8), 1'b1);
            chk("R6 fault tval", tval_o, 64'hf000_0000 + 64'(i * 8));
            chk("R6 no err", 64'(addr_missing_err), 64'h0);
            chk("R2 cause code", cause_o, 64'(list[i]));
        end
    endtask

    task automatic t_missing();
        pulse(1'b1, 1'b0, 4'd12, 64'h600, 64'h1234, 1'b0);
        chk("R7 err pulse", 64'(addr_missing_err), 64'h1);
        chk("R7 tval zero", tval_o, 64'h0);
        chk("R7 trap completes", epc_o, 64'h600);
        @(negedge clk);
        chk("R7 err one cycle", 64'(addr_missing_err), 64'h0);
    endtask

    task automatic t_break_reserved();
        pulse(1'b1, 1'b0, 4'd3, 64'h777, 64'h55, 1'b1);
        chk("R5 breakpoint tval is pc", tval_o, 64'h777);
        pulse(1'b1, 1'b0, 4'd10, 64'h780, 64'h55, 1'b0);
        chk("R5 reserved 10 tval", tval_o, 64'h0);
        chk("R5 reserved 10 no err", 64'(addr_missing_err), 64'h0);
        pulse(1'b1, 1'b0, 4'd14, 64'h784, 64'h55, 1'b1);
        chk("R5 reserved 14 tval", tval_o, 64'h0);
        chk("R2 reserved 14 cause", cause_o, 64'he);
    endtask

    task automatic t_priority();
        pulse(1'b1, 1'b1, 4'd4, 64'h888, 64'habc, 1'b1);
        chk("R9 next pc is vector", next_pc, 64'h5000);
        chk("R9 epc from trap", epc_o, 64'h888);
        chk("R9 priv machine", 64'(priv_lvl), 64'h3);
        chk("R9 mstatus trap form", mstatus_o, 64'h1800);
        chk("R9 tval", tval_o, 64'habc);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_write_ports();
        t_return();
        t_ecall();
        t_addr_causes();
        t_missing();
        t_break_reserved();
        t_priority();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule